// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides an input clock by a programmable ratio built the way a synthesizer feedback path builds it. A modelled dual-modulus prescaler counts either P or P+1 input clocks per output tick. A swallow counter loaded with A and a main counter loaded with B both count these ticks. While the swallow count is nonzero the prescaler runs at P+1. Once it reaches zero the prescaler drops to P, and the main counter finishes the cycle. The whole cycle is therefore A·(P+1) + (B−A)·P = P·B + A input clocks long. At the end of each cycle the block emits a one-clock pulse and reloads both counters.

A one-bit modulus select chooses between two prescaler bases, P_LO and P_HI. A new setting is offered with a load strobe and is range-checked. A rejected setting leaves the stored one untouched and raises a one-clock error flag. An accepted setting is staged and takes effect at the next cycle boundary, so the cycle already running always completes with its old ratio. A hold input keeps the counters in their load state. When hold is released, counting restarts from a clean cycle boundary.

Top module: `psw_divider`

## Requirements
- R1: During and right after reset, div_pulse and load_err are low. The stored setting is A_RST, B_RST and modulus select 0, so the first ratio is P_LO·B_RST + A_RST (24 at the defaults).
- R2: With modulus select 0, div_pulse repeats every P_LO·B + A input clocks.
- R3: With modulus select 1, div_pulse repeats every P_HI·B + A input clocks.
- R4: The ratio is exact at the swallow extremes A = 0 and A = B.
- R5: div_pulse is high for exactly one input clock per cycle.
- R6: An accepted load changes the ratio starting with the first cycle after the one in progress. The running cycle keeps its old length.
- R7: A load with main value B below B_MIN (3) is rejected. load_err is high for the one clock after the load edge, and the stored setting is unchanged.
- R8: A load with A > B, or with A above A_MAX (15 by default), is rejected the same way. load_err stays low after any edge without a rejected load.
- R9: While hold is high, no pulse is produced and the counters sit in their load state with the stored setting. Counting the first edge with hold low as clock 1, the first pulse follows edge number P·B + A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| hold | input | 1 | Keeps the counters in their load state |
| load | input | 1 | Offers a new setting on this edge |
| swallow_in | input | 7 | Swallow count A |
| main_in | input | 11 | Main count B |
| hi_mod | input | 1 | Modulus select: 0 uses P_LO, 1 uses P_HI |
| div_pulse | output | 1 | One-clock pulse at the end of each divided cycle |
| load_err | output | 1 | Pulses for one clock after a rejected load |

## Verification
A wrong swallow count or a wrong prescaler modulus changes only how far apart the pulses are. A single cycle with an off-by-one boundary moves every later pulse, so the per-clock reference comparison reports it at the first pulse after the fault, at most one full ratio later. A staging fault, where a new setting reaches the counters mid-cycle, shows up as a shortened or lengthened cycle right at the load. Hold faults show up either as pulses while held or as a first pulse offset from P·B + A after release.

// File: rtl/psw_pkg.sv
package psw_pkg;
    localparam int SW_W = 7;
    localparam int MN_W = 11;

    typedef struct packed {
        logic [SW_W-1:0] swc;
        logic [MN_W-1:0] mnc;
        logic            hsel;
    } psw_cfg_t;
endpackage

// File: rtl/psw_cfg_stage.sv
module psw_cfg_stage
    import psw_pkg::*;
#(
    parameter int A_MAX = 15,
    parameter int B_MIN = 3,
    parameter int A_RST = 0,
    parameter int B_RST = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SW_W-1:0] swallow_in,
    input  logic [MN_W-1:0] main_in,
    input  logic            hi_mod,
    output psw_cfg_t        staged,
    output logic            load_err
);
    localparam logic [SW_W-1:0] A_LIM = SW_W'(A_MAX);
    localparam logic [MN_W-1:0] B_LIM = MN_W'(B_MIN);

    typedef struct packed {
        psw_cfg_t cfg;
        logic     err;
    } stage_t;

    stage_t st_d, st_q;
    logic   ok;

    always_comb begin
        ok = (main_in >= B_LIM) && (swallow_in <= A_LIM) &&
             (MN_W'(swallow_in) <= main_in);
        st_d     = st_q;
        st_d.err = 1'b0;
        if (load) begin
            if (ok) begin
                st_d.cfg.swc  = swallow_in;
                st_d.cfg.mnc  = main_in;
                st_d.cfg.hsel = hi_mod;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg.swc  <= SW_W'(A_RST);
            st_q.cfg.mnc  <= MN_W'(B_RST);
            st_q.cfg.hsel <= 1'b0;
            st_q.err      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign staged   = st_q.cfg;
    assign load_err = st_q.err;
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
    parameter int P_LO = 8,
    parameter int P_HI = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hold,
    input  logic                        hsel,
    input  logic                        plus_one,
    output logic                        tick,
    output logic [$clog2(P_HI+1)-1:0]   pre_cnt
);
    localparam int PC_W = $clog2(P_HI + 1);
    localparam logic [PC_W-1:0] LAST_LO = PC_W'(P_LO - 1);
    localparam logic [PC_W-1:0] LAST_HI = PC_W'(P_HI - 1);

    logic [PC_W-1:0] cnt_d, cnt_q;
    logic [PC_W-1:0] last;

    always_comb begin
        last = hsel ? LAST_HI : LAST_LO;
        if (plus_one) last = last + 1'b1;
        tick  = !hold && (cnt_q == last);
        cnt_d = cnt_q + 1'b1;
        if (hold || tick) cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pre_cnt = cnt_q;
endmodule

// File: rtl/psw_counters.sv
module psw_counters
    import psw_pkg::*;
#(
    parameter int A_RST = 0,
    parameter int B_RST = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            tick,
    input  psw_cfg_t        staged,
    output logic [SW_W-1:0] a_cnt,
    output logic [MN_W-1:0] b_cnt,
    output logic            hsel,
    output logic            plus_one,
    output logic            div_pulse
);
    typedef struct packed {
        logic [SW_W-1:0] a;
        logic [MN_W-1:0] b;
        logic            sel;
        logic            pulse;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.pulse = 1'b0;
        if (hold) begin
            c_d.a   = staged.swc;
            c_d.b   = staged.mnc;
            c_d.sel = staged.hsel;
        end else if (tick) begin
            if (c_q.b == MN_W'(1)) begin
                c_d.a     = staged.swc;
                c_d.b     = staged.mnc;
                c_d.sel   = staged.hsel;
                c_d.pulse = 1'b1;
            end else begin
                c_d.b = c_q.b - 1'b1;
                if (c_q.a != '0) c_d.a = c_q.a - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.a     <= SW_W'(A_RST);
            c_q.b     <= MN_W'(B_RST);
            c_q.sel   <= 1'b0;
            c_q.pulse <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign a_cnt     = c_q.a;
    assign b_cnt     = c_q.b;
    assign hsel      = c_q.sel;
    assign plus_one  = (c_q.a != '0);
    assign div_pulse = c_q.pulse;
endmodule

// File: rtl/psw_divider.sv
module psw_divider
    import psw_pkg::*;
#(
    parameter int P_LO  = 8,
    parameter int P_HI  = 16,
    parameter int A_MAX = 15,
    parameter int B_MIN = 3,
    parameter int A_RST = 0,
    parameter int B_RST = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hold,
    input  logic        load,
    input  logic [6:0]  swallow_in,
    input  logic [10:0] main_in,
    input  logic        hi_mod,
    output logic        div_pulse,
    output logic        load_err
);
    localparam int PC_W = $clog2(P_HI + 1);

    psw_cfg_t        staged;
    logic            tick, hsel, plus_one;
    logic [SW_W-1:0] a_cnt;
    logic [MN_W-1:0] b_cnt;
    logic [PC_W-1:0] pre_cnt;

    psw_cfg_stage #(.A_MAX(A_MAX), .B_MIN(B_MIN), .A_RST(A_RST), .B_RST(B_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(load), .swallow_in(swallow_in),
        .main_in(main_in), .hi_mod(hi_mod), .staged(staged), .load_err(load_err)
    );

    psw_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_pre (
        .clk(clk), .rst_n(rst_n), .hold(hold), .hsel(hsel),
        .plus_one(plus_one), .tick(tick), .pre_cnt(pre_cnt)
    );

    psw_counters #(.A_RST(A_RST), .B_RST(B_RST)) u_cnt (
        .clk(clk), .rst_n(rst_n), .hold(hold), .tick(tick), .staged(staged),
        .a_cnt(a_cnt), .b_cnt(b_cnt), .hsel(hsel), .plus_one(plus_one),
        .div_pulse(div_pulse)
    );
endmodule

// File: rtl/psw_divider_chk.sv
module psw_divider_chk #(
    parameter int P_HI  = 16,
    parameter int A_MAX = 15,
    parameter int B_MIN = 3,
    parameter int PC_W  = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hold,
    input logic            load,
    input logic [6:0]      swallow_in,
    input logic [10:0]     main_in,
    input logic            div_pulse,
    input logic            load_err,
    input logic [6:0]      a_cnt,
    input logic [10:0]     b_cnt,
    input logic [PC_W-1:0] pre_cnt
);
    localparam logic [10:0]     B_LIM  = 11'(B_MIN);
    localparam logic [6:0]      A_LIM  = 7'(A_MAX);
    localparam logic [PC_W-1:0] PC_TOP = PC_W'(P_HI);

    assert_one_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !div_pulse);

    assert_short_main_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && main_in < B_LIM) |=> load_err);

    assert_bad_swallow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (11'(swallow_in) > main_in || swallow_in > A_LIM)) |=> load_err);

    assert_no_idle_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> !load_err);

    assert_swallow_le_main_R2: assert property (@(posedge clk) disable iff (!rst_n)
        11'(a_cnt) <= b_cnt);

    assert_pre_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= PC_TOP);
endmodule

bind psw_divider psw_divider_chk #(.P_HI(P_HI), .A_MAX(A_MAX), .B_MIN(B_MIN), .PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hold(hold), .load(load), .swallow_in(swallow_in),
    .main_in(main_in), .div_pulse(div_pulse), .load_err(load_err),
    .a_cnt(a_cnt), .b_cnt(b_cnt), .pre_cnt(pre_cnt)
);

// File: tb/psw_divider_test.sv
module psw_divider_test;
    localparam int PL = 8;
    localparam int PH = 16;
    localparam int AMX = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold = 1'b0;
    logic        load = 1'b0;
    logic [6:0]  swallow_in = '0;
    logic [10:0] main_in = '0;
    logic        hi_mod = 1'b0;
    logic        div_pulse, load_err;

    int    compared = 0;
    int    mismatched = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // reference model state
    int sh_a = 0, sh_b = 3, sh_s = 0;
    int cur_n = PL * 3;
    int cnt = 0;
    bit exp_pulse = 1'b0, exp_err = 1'b0;
    bit prev_pulse = 1'b0;

    always #10 clk = ~clk;

    psw_divider uut (
        .clk(clk), .rst_n(rst_n), .hold(hold), .load(load),
        .swallow_in(swallow_in), .main_in(main_in), .hi_mod(hi_mod),
        .div_pulse(div_pulse), .load_err(load_err)
    );

    function automatic int ratio(int a, int b, int s);
        return (s != 0 ? PH : PL) * b + a;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            sh_a = 0; sh_b = 3; sh_s = 0;
            cur_n = ratio(0, 3, 0);
            cnt = 0; exp_pulse = 1'b0; exp_err = 1'b0;
        end else begin
            if (hold) begin
                cnt = 0;
                cur_n = ratio(sh_a, sh_b, sh_s);
                exp_pulse = 1'b0;
            end else begin
                cnt++;
                if (cnt == cur_n) begin
                    exp_pulse = 1'b1;
                    cnt = 0;
                    cur_n = ratio(sh_a, sh_b, sh_s);
                end else begin
                    exp_pulse = 1'b0;
                end
            end
            exp_err = 1'b0;
            if (load) begin
                if (int'(main_in) >= 3 && int'(swallow_in) <= AMX &&
                    int'(swallow_in) <= int'(main_in)) begin
                    sh_a = int'(swallow_in); sh_b = int'(main_in); sh_s = int'(hi_mod);
                end else begin
                    exp_err = 1'b1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            compared++;
            if (div_pulse !== exp_pulse) begin
                mismatched++;
                $display("FAIL %s div_pulse actual=%0b expected=%0b at %0t", cur_req, div_pulse, exp_pulse, $time);
            end
            compared++;
            if (load_err !== exp_err) begin
                mismatched++;
                $display("FAIL %s load_err actual=%0b expected=%0b at %0t", cur_req, load_err, exp_err, $time);
            end
            if (div_pulse === 1'b1) begin
                compared++;
                if (prev_pulse) begin
                    mismatched++;
                    $display("FAIL R5 pulse width actual=2+ expected=1 at %0t", $time);
                end
            end
            prev_pulse = (div_pulse === 1'b1);
        end
    end

    task automatic offer(input int a, input int b, input bit s);
        @(negedge clk);
        load = 1'b1; swallow_in = 7'(a); main_in = 11'(b); hi_mod = s;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog actual=running expected=finished");
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        run(3);
        rst_n = 1'b1;
        run(80);               // default ratio 24 (R1)
        cur_req = "R2";
        offer(2, 5, 1'b0);     // 42
        run(140);
        cur_req = "R3";
        offer(3, 4, 1'b1);     // 67
        run(210);
        cur_req = "R4";
        offer(0, 3, 1'b1);     // 48, A = 0
        run(150);
        offer(7, 7, 1'b0);     // 63, A = B
        run(200);
        cur_req = "R6";
        run(20);
        offer(1, 3, 1'b0);     // staged mid-cycle
        run(5);
        offer(4, 6, 1'b1);     // replaces it before the boundary
        run(300);
        cur_req = "R7";
        offer(0, 2, 1'b0);
        run(10);
        offer(1, 0, 1'b1);
        run(200);
        cur_req = "R8";
        offer(5, 4, 1'b0);
        run(5);
        offer(16, 20, 1'b0);
        run(5);
        offer(15, 15, 1'b0);   // legal edge of A_MAX, 135
        run(300);
        cur_req = "R9";
        run(37);
        @(negedge clk) hold = 1'b1;
        run(30);
        offer(2, 3, 1'b1);     // loaded while held, 50
        run(10);
        @(negedge clk) hold = 1'b0;
        run(170);
        @(negedge clk) hold = 1'b1;
        @(negedge clk) hold = 1'b0;
        run(120);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule